// File: doc/BRIEF.md
# Paced Sample Stream Player

This block plays a buffer of 16-bit samples into a PWM compare value at a fixed sample rate. Software gives a base word address, a sample count, a pacing period in clock cycles and a mode, then pulses `start`. The pacing period is the system clock frequency divided by the sample rate, for example 84 MHz / 8 kHz = 10500. A pacing divider then raises one read request per period on a simple request/acknowledge memory port. Each returned word becomes the new compare value, and the read address advances by one word.

While a stream is active the block holds the channel enable and the tone lock. It also gives a one-cycle pulse that tells the beep timer to drop any pending duration. In one-shot mode the stream ends by itself after the last sample. In circular mode the address and count wrap to their start values, so a double buffer can be refilled while it plays. Midpoint and wrap events are kept in sticky flags that are cleared by writing a one. A stop command or an error response from memory ends the stream at once.

Top module: `stream_player`

## Requirements
- R1: After reset, every output is 0, including the compare value, the request, the address, the channel enable, the lock, busy and all flags.
- R2: A `start` that is accepted while idle (`start_len` and `start_period` both nonzero, `stop` low) has these effects on the next cycle: `chan_en` and `tone_lock` go to 1, `cmp_value` goes to 0, `mem_addr` goes to `start_addr`, and `beep_clear` pulses for exactly one cycle.
- R3: A `start` with `start_len` of 0, with `start_period` of 0, or given while a stream is already active, changes nothing.
- R4: With period P, the pacer ticks on every P-th clock edge after the accepting edge. A tick raises `mem_req` when no request is outstanding. `mem_req` stays high until `mem_ack` or `mem_err` is seen. A tick that comes while a request is outstanding is dropped.
- R5: On an edge where `mem_req` and `mem_ack` are high, `cmp_value` takes `mem_rdata` and `mem_addr` advances by 1 (it wraps modulo 2^16).
- R6: In one-shot mode (`start_circ`=0), after `start_len` transfers, `chan_en`, `tone_lock` and `mem_req` drop on the next cycle and the done flag is set.
- R7: In circular mode (`start_circ`=1), after `start_len` transfers, `mem_addr` returns to the start address, playback continues and the done flag is set.
- R8: In circular mode the half flag is set on the transfer that brings the number moved in the current pass to floor(`start_len`/2). It is never set when `start_len` is 1.
- R9: `stop` makes `chan_en`, `tone_lock` and `mem_req` drop on the next cycle, clears the half and done flags and ends circular mode. `stop` wins over a `start` given in the same cycle.
- R10: `mem_err` while a request is outstanding ends the stream the way `stop` does and sets `err_flag`. An error wins over an acknowledge given in the same cycle.
- R11: `evt_clr` bit 0 clears the half flag, bit 1 clears the done flag and bit 2 clears the error flag. If a flag is set and cleared in the same cycle, the set wins.
- R12: `busy` always equals `chan_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request pulse |
| start_circ | input | 1 | 1 selects circular mode, 0 selects one-shot mode |
| start_addr | input | 16 | Base word address of the buffer |
| start_len | input | 16 | Number of samples in the buffer |
| start_period | input | 16 | Clock cycles per sample |
| stop | input | 1 | Immediate stop command |
| evt_clr | input | 3 | Write-one-to-clear for the half, done and error flags |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read word address |
| mem_ack | input | 1 | Read data valid |
| mem_err | input | 1 | Read error response |
| mem_rdata | input | 16 | Read data |
| cmp_value | output | 16 | PWM compare value |
| chan_en | output | 1 | Output channel enable |
| busy | output | 1 | Channel busy status |
| tone_lock | output | 1 | Lock toward the tone generator |
| beep_clear | output | 1 | One-cycle pulse that cancels a pending beep duration |
| evt_half | output | 1 | Sticky half-transfer flag |
| evt_done | output | 1 | Sticky complete-transfer flag |
| err_flag | output | 1 | Sticky transfer error flag |

## Verification
The bench drives a memory whose latency is longer than one sample period. A design that queued ticks instead of dropping them would issue extra reads and run out of step with the reference. Buffers of length 1 and odd lengths test the midpoint rule: if the midpoint were taken as a rounded-up half, or if it fired for a single sample, the half flag would come one transfer late or appear when it should not. The bench also makes `stop` and `start` land in the same cycle, makes an error answer arrive mid-stream, issues a restart while a stream is active, and clears flags in the cycle they are set. A design with the wrong priority in any of these would leave the channel enabled or lose a flag.

// File: rtl/stream_player_pkg.sv
package stream_player_pkg;
    localparam int FLAG_HALF = 0;
    localparam int FLAG_DONE = 1;
    localparam int FLAG_ERR  = 2;
    localparam int FLAG_N    = 3;
endpackage

// File: rtl/stream_pacer.sv
module stream_pacer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [PER_W-1:0] period_in,
    output logic             tick
);
    typedef struct packed {
        logic [PER_W-1:0] period;
        logic [PER_W-1:0] cnt;
    } pacer_t;

    pacer_t st_d, st_q;

    assign tick = run && !load && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.period = period_in;
            st_d.cnt    = period_in - 1'b1;
        end else if (run) begin
            if (st_q.cnt == '0) st_d.cnt = st_q.period - 1'b1;
            else                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/stream_fetch.sv
module stream_fetch #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              run,
    input  logic              abort,
    input  logic              circ,
    input  logic              tick,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              xfer,
    output logic              last,
    output logic [LEN_W-1:0]  remain
);
    typedef struct packed {
        logic              req;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
    } fetch_t;

    fetch_t st_d, st_q;

    assign mem_req  = st_q.req;
    assign mem_addr = st_q.addr;
    assign remain   = st_q.cnt;
    assign last     = (st_q.cnt == LEN_W'(1));
    assign xfer     = run && !abort && st_q.req && mem_ack && !mem_err;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.addr = base_in;
            st_d.base = base_in;
            st_d.cnt  = len_in;
            st_d.len  = len_in;
            st_d.req  = 1'b0;
        end else if (abort || !run) begin
            st_d.req = 1'b0;
        end else if (xfer) begin
            st_d.req = 1'b0;
            if (last && circ) begin
                st_d.addr = st_q.base;
                st_d.cnt  = st_q.len;
            end else begin
                st_d.addr = st_q.addr + 1'b1;
                st_d.cnt  = st_q.cnt - 1'b1;
            end
        end else if (tick && !st_q.req) begin
            st_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/stream_player.sv
module stream_player #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16,
    parameter int PER_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_circ,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [PER_W-1:0]  start_period,
    input  logic              stop,
    input  logic [2:0]        evt_clr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] cmp_value,
    output logic              chan_en,
    output logic              busy,
    output logic              tone_lock,
    output logic              beep_clear,
    output logic              evt_half,
    output logic              evt_done,
    output logic              err_flag
);
    import stream_player_pkg::*;

    localparam int MARK_W = LEN_W + 1;

    typedef struct packed {
        logic              active;
        logic              circ;
        logic              beep;
        logic [FLAG_N-1:0] flags;
        logic [DATA_W-1:0] cmp;
        logic [MARK_W-1:0] half_mark;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic             start_ok, err_abort, abort;
    logic             tick, xfer, last;
    logic [LEN_W-1:0] remain;
    logic [FLAG_N-1:0] flag_set;

    assign start_ok  = start && !stop && !st_q.active &&
                       (start_len != '0) && (start_period != '0);
    assign err_abort = st_q.active && mem_req && mem_err;
    assign abort     = stop || err_abort;

    stream_pacer #(.PER_W(PER_W)) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_ok),
        .run       (st_q.active),
        .period_in (start_period),
        .tick      (tick)
    );

    stream_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .base_in  (start_addr),
        .len_in   (start_len),
        .run      (st_q.active),
        .abort    (abort),
        .circ     (st_q.circ),
        .tick     (tick),
        .mem_ack  (mem_ack),
        .mem_err  (mem_err),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .xfer     (xfer),
        .last     (last),
        .remain   (remain)
    );

    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_HALF] = xfer && st_q.circ && ({1'b0, remain} == st_q.half_mark);
        flag_set[FLAG_DONE] = xfer && last;
        flag_set[FLAG_ERR]  = err_abort && !stop;

        st_d      = st_q;
        st_d.beep = 1'b0;
        if (abort) begin
            st_d.active = 1'b0;
            st_d.circ   = 1'b0;
        end else if (start_ok) begin
            st_d.active    = 1'b1;
            st_d.circ      = start_circ;
            st_d.beep      = 1'b1;
            st_d.cmp       = '0;
            st_d.half_mark = {1'b0, start_len} - {2'b0, start_len[LEN_W-1:1]} + 1'b1;
        end else if (xfer) begin
            st_d.cmp = mem_rdata;
            if (last && !st_q.circ) st_d.active = 1'b0;
        end

        st_d.flags = (st_q.flags & ~evt_clr) | flag_set;
        if (abort) begin
            st_d.flags[FLAG_HALF] = 1'b0;
            st_d.flags[FLAG_DONE] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_value  = st_q.cmp;
    assign chan_en    = st_q.active;
    assign busy       = st_q.active;
    assign tone_lock  = st_q.active;
    assign beep_clear = st_q.beep;
    assign evt_half   = st_q.flags[FLAG_HALF];
    assign evt_done   = st_q.flags[FLAG_DONE];
    assign err_flag   = st_q.flags[FLAG_ERR];
endmodule

// File: rtl/stream_player_sva.sv
module stream_player_sva #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16,
    parameter int PER_W  = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  start_len,
    input logic [PER_W-1:0]  start_period,
    input logic              stop,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_err,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] cmp_value,
    input logic              chan_en,
    input logic              tone_lock,
    input logic              beep_clear,
    input logic              evt_half,
    input logic              evt_done,
    input logic              err_flag
);
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !stop && !chan_en && start_len != '0 && start_period != '0
        |=> chan_en && tone_lock && beep_clear && cmp_value == '0);

    assert_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start && !chan_en && (start_len == '0 || start_period == '0)
        |=> !chan_en);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !mem_err && !stop |=> mem_req);

    assert_req_in_stream_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> chan_en);

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && mem_req && mem_ack && !mem_err && !stop
        |=> cmp_value == $past(mem_rdata));

    assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !chan_en && !tone_lock && !mem_req && !evt_half && !evt_done);

    assert_err_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && mem_req && mem_err && !stop |=> err_flag && !chan_en);
endmodule

bind stream_player stream_player_sva #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PER_W(PER_W), .DATA_W(DATA_W)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .start_len    (start_len),
    .start_period (start_period),
    .stop         (stop),
    .mem_req      (mem_req),
    .mem_ack      (mem_ack),
    .mem_err      (mem_err),
    .mem_rdata    (mem_rdata),
    .cmp_value    (cmp_value),
    .chan_en      (chan_en),
    .tone_lock    (tone_lock),
    .beep_clear   (beep_clear),
    .evt_half     (evt_half),
    .evt_done     (evt_done),
    .err_flag     (err_flag)
);

// File: tb/stream_player_tb.sv
`timescale 1ns/1ps
module stream_player_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0, start_circ = 0, stop = 0;
    logic [15:0] start_addr = 0, start_len = 0, start_period = 0;
    logic [2:0]  evt_clr = 0;
    logic        mem_req, mem_ack = 0, mem_err = 0;
    logic [15:0] mem_addr, mem_rdata, cmp_value;
    logic        chan_en, busy, tone_lock, beep_clear, evt_half, evt_done, err_flag;

    always #5 clk = ~clk;

    stream_player u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_circ(start_circ),
        .start_addr(start_addr), .start_len(start_len), .start_period(start_period),
        .stop(stop), .evt_clr(evt_clr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .cmp_value(cmp_value), .chan_en(chan_en), .busy(busy), .tone_lock(tone_lock),
        .beep_clear(beep_clear), .evt_half(evt_half), .evt_done(evt_done),
        .err_flag(err_flag)
    );

    function automatic int rd_word(int a);
        return (a * 37 + 'h1234) & 'hFFFF;
    endfunction

    assign mem_rdata = 16'(rd_word(int'(mem_addr)));

    int    n_vec = 0, n_fail = 0;
    string phase = "R1";
    bit    finished = 0;

    // Memory responder: configurable latency and one-shot error injection
    int lat = 0, wait_cnt = 0;
    bit inject_err = 0;
    always @(negedge clk) begin
        if (mem_req && !mem_ack && !mem_err) begin
            if (wait_cnt >= lat) begin
                if (inject_err) begin mem_err <= 1; inject_err <= 0; end
                else mem_ack <= 1;
                wait_cnt <= 0;
            end else wait_cnt <= wait_cnt + 1;
        end else begin
            mem_ack <= 0; mem_err <= 0; wait_cnt <= 0;
        end
    end

    // Behavioural reference model
    int m_act, m_circ, m_req, m_cmp, m_addr, m_base, m_len, m_cnt, m_per, m_div;
    int m_beep, m_half, m_done, m_err;
    always @(posedge clk) begin
        bit ab, sh, sd, se, tk;
        int moved;
        sh = 0; sd = 0; se = 0;
        if (!rst_n) begin
            m_act = 0; m_circ = 0; m_req = 0; m_cmp = 0; m_addr = 0; m_base = 0;
            m_len = 0; m_cnt = 0; m_per = 0; m_div = 0; m_beep = 0;
            m_half = 0; m_done = 0; m_err = 0;
        end else begin
            m_beep = 0;
            ab = stop || (m_act != 0 && m_req != 0 && mem_err);
            if (stop) begin
                m_act = 0; m_req = 0; m_circ = 0;
            end else if (ab) begin
                m_act = 0; m_req = 0; m_circ = 0; se = 1;
            end else if (m_act != 0) begin
                tk = (m_div == 0);
                m_div = tk ? m_per - 1 : m_div - 1;
                if (m_req != 0 && mem_ack) begin
                    moved = m_len - m_cnt + 1;
                    m_cmp = rd_word(m_addr);
                    m_req = 0;
                    m_addr = (m_addr + 1) & 'hFFFF;
                    if (m_circ != 0 && moved == m_len / 2) sh = 1;
                    if (m_cnt == 1) begin
                        sd = 1;
                        if (m_circ != 0) begin m_addr = m_base; m_cnt = m_len; end
                        else m_act = 0;
                    end else m_cnt = m_cnt - 1;
                end else if (m_req == 0 && tk) m_req = 1;
            end else if (start && start_len != 0 && start_period != 0) begin
                m_act = 1; m_circ = int'(start_circ); m_beep = 1; m_cmp = 0; m_req = 0;
                m_base = int'(start_addr); m_addr = m_base; m_len = int'(start_len);
                m_cnt = m_len; m_per = int'(start_period); m_div = m_per - 1;
            end
            m_half = ab ? 0 : int'((m_half != 0 && !evt_clr[0]) || sh);
            m_done = ab ? 0 : int'((m_done != 0 && !evt_clr[1]) || sd);
            m_err  = int'((m_err != 0 && !evt_clr[2]) || se);
        end
    end

    task automatic cmpv(string nm, int act, int exp);
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", phase, nm, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_vec++;
            cmpv("cmp_value", int'(cmp_value), m_cmp);
            cmpv("mem_req", int'(mem_req), m_req);
            cmpv("mem_addr", int'(mem_addr), m_addr);
            cmpv("chan_en", int'(chan_en), m_act);
            cmpv("tone_lock", int'(tone_lock), m_act);
            cmpv("busy_R12", int'(busy), m_act);
            cmpv("beep_clear", int'(beep_clear), m_beep);
            cmpv("evt_half", int'(evt_half), m_half);
            cmpv("evt_done", int'(evt_done), m_done);
            cmpv("err_flag", int'(err_flag), m_err);
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go(bit circ, int addr, int len, int per);
        @(negedge clk);
        start = 1; start_circ = circ; start_addr = 16'(addr);
        start_len = 16'(len); start_period = 16'(per);
        @(negedge clk);
        start = 0;
    endtask

    task automatic halt();
        @(negedge clk); stop = 1;
        @(negedge clk); stop = 0;
    endtask

    task automatic clr(int bits);
        @(negedge clk); evt_clr = 3'(bits);
        @(negedge clk); evt_clr = 0;
    endtask

    initial begin
        cyc(3);
        // R1: reset state
        check(cmp_value == 0 && !mem_req && mem_addr == 0 && !chan_en && !busy &&
              !tone_lock && !beep_clear && !evt_half && !evt_done && !err_flag,
              "R1 reset outputs", int'(chan_en), 0);
        @(negedge clk); rst_n = 1;

        // R2 / R12: accepted one-shot start, then R6 end of stream
        phase = "R2"; lat = 0;
        go(0, 'h100, 4, 3);
        check(chan_en && tone_lock && beep_clear && cmp_value == 0, "R2 start effects", int'(chan_en), 1);
        check(busy == chan_en, "R12 busy follows enable", int'(busy), int'(chan_en));
        phase = "R5"; cyc(10);
        phase = "R6"; cyc(12);
        check(!chan_en && evt_done, "R6 one-shot end", int'(chan_en), 0);

        // R3: rejected starts
        phase = "R3";
        go(0, 'h10, 0, 3);
        check(!chan_en, "R3 zero length rejected", int'(chan_en), 0);
        go(0, 'h10, 5, 0);
        check(!chan_en, "R3 zero period rejected", int'(chan_en), 0);

        // R11: clear done
        phase = "R11"; clr(2);
        check(!evt_done, "R11 done cleared", int'(evt_done), 0);

        // R7 / R8: circular, odd length, latency 1
        phase = "R7"; lat = 1;
        go(1, 'hFFFE, 5, 2);
        cyc(12);
        phase = "R3"; go(0, 'h40, 3, 7); // ignored while active
        phase = "R8"; cyc(20);
        check(evt_half && evt_done, "R8 R7 circular flags", int'(evt_half), 1);
        phase = "R11";
        // clear while transfers keep setting flags
        @(negedge clk); evt_clr = 3'b011; cyc(9); evt_clr = 0;
        cyc(6);
        phase = "R9"; halt();
        check(!chan_en && !evt_half && !evt_done, "R9 stop", int'(chan_en), 0);

        // R10: error mid-stream
        phase = "R10"; lat = 0;
        go(0, 'h200, 6, 2);
        cyc(5); inject_err = 1; cyc(6);
        check(err_flag && !chan_en, "R10 error abort", int'(err_flag), 1);
        phase = "R11"; clr(4);
        check(!err_flag, "R11 err cleared", int'(err_flag), 0);

        // R9: stop and start in the same cycle
        phase = "R9";
        @(negedge clk);
        stop = 1; start = 1; start_len = 4; start_period = 2; start_circ = 0;
        @(negedge clk); stop = 0; start = 0;
        check(!chan_en, "R9 stop beats start", int'(chan_en), 0);

        // R4: ticks while a request is outstanding are dropped
        phase = "R4"; lat = 2;
        go(0, 'h300, 3, 1);
        cyc(20);
        check(!chan_en && evt_done, "R4 slow memory stream ends", int'(chan_en), 0);
        clr(2);

        // R8: single-sample circular buffer never raises half
        phase = "R8"; lat = 0;
        go(1, 'h50, 1, 1);
        cyc(12);
        check(!evt_half && evt_done, "R8 len 1 no half", int'(evt_half), 0);
        phase = "R9"; halt();
        cyc(3);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog act=0 exp=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule